// File: doc/BRIEF.md
# Lockable Per-Pin Function Multiplexer

This block connects 48 pads, arranged as three ports of sixteen pins, to sixteen peripheral function groups. Each pad has its own 4-bit selector. The selector picks which group drives the pad's output value and output enable, and which group receives the pad's input. The selectors are stored in configuration words behind a simple 32-bit register interface. The same interface also holds two interrupt source selection words, which the block drives straight out to the interrupt controller.

A per-pin availability mask is set by a parameter. When a pin selects a group that the mask marks as absent, the pin behaves exactly as if group 0, the default system function, were selected. A per-pin lock input makes that pin's selector read-only until the next reset. The register interface is a control path, so it uses plain strobes with no back-pressure. Every request completes in the cycle it is presented, and there is no ready signal. The pad and function paths are purely combinational routing and carry no handshake.

Top module: `pin_func_mux`

## Requirements
- R1: After reset every selector, both interrupt words and every lock are zero, so every pad is routed to group 0.
- R2: The configuration words live at byte offsets 0x020 to 0x034, two per port. Port A uses 0x020 and 0x024, port B uses 0x028 and 0x02C, and port C uses 0x030 and 0x034. The lower word of a port covers pins 0 to 7 and the upper word covers pins 8 to 15. Pin n of a word sits at bits [4n+3:4n].
- R3: A read returns the stored word on `reg_rdata` in the cycle after the request. `reg_rdata` is zero in the cycle after any cycle without a read. A read returns the stored selector, even when that selector names an absent group.
- R4: The interrupt selection words live at 0x000 and 0x004. They can be written and read at any time, locks do not affect them, and they appear on `irq_sel0` and `irq_sel1` from the cycle after the write.
- R5: Pad p (p = port·16 + pin, ports A=0, B=1, C=2) takes `pad_out[p]` from `func_out[f·48+p]` and `pad_oe[p]` from `func_oe[f·48+p]`, where f is its effective group. A new selector takes effect in the cycle after its write.
- R6: The effective group is the selector when availability bit `AVAIL_MASK[p·16+sel]` is set, and 0 otherwise. The default mask is 16'hA0F7 for every pin, which makes groups 0, 1, 2, 4, 5, 6, 7, 13 and 15 present.
- R7: `func_in[f·48+p]` equals `pad_in[p]` for the effective group f of pad p. Every other group sees 0 for that pad.
- R8: A cycle with `pin_lock[p]` high locks pin p until reset. A write in that cycle or any later cycle leaves the pin's field unchanged, while unlocked fields of the same word still update.
- R9: Reads of unmapped offsets or misaligned offsets (address bits [1:0] not zero) return zero. Writes to them change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| pin_lock | input | 48 | Per-pin lock request, sticky until reset |
| irq_sel0 | output | 32 | Interrupt source selection word 0 |
| irq_sel1 | output | 32 | Interrupt source selection word 1 |
| func_out | input | 768 | Output value from each group for each pad, index f·48+p |
| func_oe | input | 768 | Output enable from each group for each pad, index f·48+p |
| func_in | output | 768 | Pad input delivered to each group, index f·48+p |
| pad_out | output | 48 | Output value to the pads |
| pad_oe | output | 48 | Output enable to the pads |
| pad_in | input | 48 | Input value from the pads |

## Verification
Pad routing is combinational, so `pad_out`, `pad_oe` and `func_in` are due in the same cycle as new function or pad data. They move only in the cycle after a selector write is clocked in. Read data, interrupt words and lock state are each due exactly one edge after the request.

The bench drives inputs 2 ns after a rising edge and compares every output against a behavioural model at the falling edge. The model is updated at the rising edge from the same sampled inputs the design sees, so each result is checked in the first cycle it is due.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  // Word indices (byte offset / 4) of the register windows
  localparam int unsigned PMX_IRQ0_IDX     = 0;
  localparam int unsigned PMX_IRQ1_IDX     = 1;
  localparam int unsigned PMX_CFG_BASE_IDX = 8;

  // Default per-pin presence of function groups (bit f = group f present)
  localparam logic [15:0] PMX_AVAIL_ROW = 16'hA0F7;

  typedef enum logic [3:0] {
    FN_SYS     = 4'd0,
    FN_GPIO    = 4'd1,
    FN_ADC     = 4'd2,
    FN_TIMER   = 4'd4,
    FN_SPI     = 4'd5,
    FN_UART    = 4'd6,
    FN_I2C     = 4'd7,
    FN_PWM     = 4'd13,
    FN_SYS_AUX = 4'd15
  } pmx_func_e;
endpackage

// File: rtl/pmx_regbank.sv
module pmx_regbank
  import pmx_pkg::*;
#(
  parameter int unsigned N_PORTS = 3,
  parameter int unsigned PINS    = 16,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_en,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [N_PORTS*PINS-1:0]     pin_lock,
  output logic [N_PORTS*PINS*SEL_W-1:0] sel_flat,
  output logic [DATA_W-1:0]           irq_sel0,
  output logic [DATA_W-1:0]           irq_sel1
);
  localparam int unsigned NPIN   = N_PORTS * PINS;
  localparam int unsigned PPW    = DATA_W / SEL_W;
  localparam int unsigned NWORDS = NPIN / PPW;
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned CW_W   = $clog2(NWORDS);

  logic [WIDX_W-1:0]           widx;
  logic                        aligned, wr_req, rd_req, cfg_hit;
  logic                        irq0_hit, irq1_hit;
  logic [CW_W-1:0]             cfg_word;
  logic [NPIN-1:0][SEL_W-1:0]  sel_q;
  logic [NPIN-1:0]             locked_q, lock_eff, pin_we;
  logic [NWORDS-1:0][DATA_W-1:0] cfg_words;
  logic [DATA_W-1:0]           irq0_q, irq1_q, rd_word, rdata_q;

  assign widx     = reg_addr[ADDR_W-1:2];
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign wr_req   = reg_en & reg_wr & aligned;
  assign rd_req   = reg_en & ~reg_wr;
  assign cfg_hit  = (widx >= WIDX_W'(PMX_CFG_BASE_IDX)) &&
                    (widx <  WIDX_W'(PMX_CFG_BASE_IDX + NWORDS));
  assign cfg_word = CW_W'(widx - WIDX_W'(PMX_CFG_BASE_IDX));
  assign irq0_hit = (widx == WIDX_W'(PMX_IRQ0_IDX));
  assign irq1_hit = (widx == WIDX_W'(PMX_IRQ1_IDX));
  assign lock_eff = locked_q | pin_lock;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int unsigned WORD = p / PPW;
    localparam int unsigned SLOT = p % PPW;

    assign pin_we[p] = wr_req & cfg_hit & (cfg_word == CW_W'(WORD)) & ~lock_eff[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[p]    <= '0;
        locked_q[p] <= 1'b0;
      end else begin
        if (pin_we[p]) sel_q[p] <= reg_wdata[SLOT*SEL_W +: SEL_W];
        if (pin_lock[p]) locked_q[p] <= 1'b1;
      end
    end

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q[p] |=> $stable(sel_q[p]));
    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q[p] |=> locked_q[p]);
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign cfg_words[w] = sel_q[w*PPW +: PPW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_q <= '0;
      irq1_q <= '0;
    end else if (wr_req) begin
      if (irq0_hit) irq0_q <= reg_wdata;
      if (irq1_hit) irq1_q <= reg_wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      if (cfg_hit)       rd_word = cfg_words[cfg_word];
      else if (irq0_hit) rd_word = irq0_q;
      else if (irq1_hit) rd_word = irq1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_word;
    else             rdata_q <= '0;
  end

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !(aligned && (cfg_hit || irq0_hit || irq1_hit))) |=> (reg_rdata == '0));
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && (irq0_hit || irq1_hit)) |=> ($stable(irq_sel0) && $stable(irq_sel1)));

  assign sel_flat  = sel_q;
  assign reg_rdata = rdata_q;
  assign irq_sel0  = irq0_q;
  assign irq_sel1  = irq1_q;
endmodule

// File: rtl/pmx_route.sv
module pmx_route #(
  parameter int unsigned NPIN  = 48,
  parameter int unsigned NFUNC = 16,
  parameter int unsigned SEL_W = 4,
  parameter logic [NPIN*NFUNC-1:0] AVAIL = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPIN*SEL_W-1:0]   sel_flat,
  input  logic [NFUNC*NPIN-1:0]   func_out,
  input  logic [NFUNC*NPIN-1:0]   func_oe,
  output logic [NFUNC*NPIN-1:0]   func_in,
  output logic [NPIN-1:0]         pad_out,
  output logic [NPIN-1:0]         pad_oe,
  input  logic [NPIN-1:0]         pad_in
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [NFUNC-1:0] fo_v, oe_v, fi_v, av_v;
    logic [SEL_W-1:0] sel, eff;

    assign sel  = sel_flat[p*SEL_W +: SEL_W];
    assign av_v = AVAIL[p*NFUNC +: NFUNC];
    assign eff  = av_v[sel] ? sel : '0;

    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      assign fo_v[f] = func_out[f*NPIN + p];
      assign oe_v[f] = func_oe[f*NPIN + p];
      assign fi_v[f] = (eff == SEL_W'(f)) & pad_in[p];
      assign func_in[f*NPIN + p] = fi_v[f];
    end

    assign pad_out[p] = fo_v[eff];
    assign pad_oe[p]  = oe_v[eff];

    // R6
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !av_v[sel] |-> (pad_out[p] == fo_v[0] && pad_oe[p] == oe_v[0]));
    // R7
    fin_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fi_v));
  end
endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux
  import pmx_pkg::*;
#(
  parameter int unsigned N_PORTS = 3,
  parameter int unsigned PINS    = 16,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NFUNC   = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [N_PORTS*PINS*NFUNC-1:0] AVAIL_MASK = {(N_PORTS*PINS){PMX_AVAIL_ROW}}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_en,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic [N_PORTS*PINS-1:0]       pin_lock,
  output logic [DATA_W-1:0]             irq_sel0,
  output logic [DATA_W-1:0]             irq_sel1,
  input  logic [NFUNC*N_PORTS*PINS-1:0] func_out,
  input  logic [NFUNC*N_PORTS*PINS-1:0] func_oe,
  output logic [NFUNC*N_PORTS*PINS-1:0] func_in,
  output logic [N_PORTS*PINS-1:0]       pad_out,
  output logic [N_PORTS*PINS-1:0]       pad_oe,
  input  logic [N_PORTS*PINS-1:0]       pad_in
);
  localparam int unsigned NPIN = N_PORTS * PINS;

  logic [NPIN*SEL_W-1:0] sel_flat;

  pmx_regbank #(
    .N_PORTS(N_PORTS), .PINS(PINS), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_lock(pin_lock), .sel_flat(sel_flat),
    .irq_sel0(irq_sel0), .irq_sel1(irq_sel1)
  );

  pmx_route #(
    .NPIN(NPIN), .NFUNC(NFUNC), .SEL_W(SEL_W), .AVAIL(AVAIL_MASK)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .sel_flat(sel_flat),
    .func_out(func_out), .func_oe(func_oe), .func_in(func_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );
endmodule

// File: tb/pin_func_mux_tb_top.sv
`timescale 1ns/1ps
module pin_func_mux_tb_top;
  localparam int NP = 48;
  localparam int NF = 16;
  localparam logic [15:0] AV = 16'hA0F7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_en = 1'b0, reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata, irq_sel0, irq_sel1;
  logic [NP-1:0] pin_lock = '0;
  logic [NF*NP-1:0] func_out = '0, func_oe = '0, func_in;
  logic [NP-1:0] pad_out, pad_oe, pad_in = '0;

  int checks = 0, bad = 0;
  bit done = 0;

  int          m_sel [NP];
  bit          m_lock[NP];
  logic [31:0] m_irq [2];
  logic [31:0] m_rd;
  bit          m_rd_unm;

  always #10 clk = ~clk;

  pin_func_mux dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_lock(pin_lock), .irq_sel0(irq_sel0), .irq_sel1(irq_sel1),
    .func_out(func_out), .func_oe(func_oe), .func_in(func_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  function automatic int eff_of(int p);
    int s = m_sel[p];
    return AV[s] ? s : 0;
  endfunction

  function automatic bit mapped(logic [7:0] a);
    int w = int'(a >> 2);
    if (a[1:0] != 2'b00) return 0;
    return (w == 0 || w == 1 || (w >= 8 && w <= 13));
  endfunction

  function automatic logic [31:0] ref_read(logic [7:0] a);
    logic [31:0] v = '0;
    int w = int'(a >> 2);
    if (!mapped(a)) return '0;
    if (w < 2) return m_irq[w];
    for (int k = 0; k < 8; k++) v[4*k +: 4] = 4'(m_sel[(w-8)*8 + k]);
    return v;
  endfunction

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    logic [31:0] nr;
    int w;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_sel[p] = 0; m_lock[p] = 0; end
      m_irq[0] = '0; m_irq[1] = '0; m_rd = '0; m_rd_unm = 0;
    end else begin
      nr = '0;
      m_rd_unm = 0;
      if (reg_en && !reg_wr) begin nr = ref_read(reg_addr); m_rd_unm = !mapped(reg_addr); end
      if (reg_en && reg_wr && mapped(reg_addr)) begin
        w = int'(reg_addr >> 2);
        if (w < 2) m_irq[w] = reg_wdata;
        else for (int k = 0; k < 8; k++)
          if (!(m_lock[(w-8)*8+k] || pin_lock[(w-8)*8+k]))
            m_sel[(w-8)*8+k] = int'(reg_wdata[4*k +: 4]);
      end
      for (int p = 0; p < NP; p++) if (pin_lock[p]) m_lock[p] = 1;
      m_rd = nr;
    end
  end

  // Compare every cycle at the falling edge
  always @(negedge clk) begin
    logic [NF*NP-1:0] efi;
    int e;
    if (rst_n && !done) begin
      efi = '0;
      for (int p = 0; p < NP; p++) begin
        e = eff_of(p);
        efi[e*NP + p] = pad_in[p];
        checks++;
        if (pad_out[p] !== func_out[e*NP+p] || pad_oe[p] !== func_oe[e*NP+p]) begin
          bad++;
          $display("FAIL %s pad %0d out/oe act=%b%b exp=%b%b", (e != m_sel[p]) ? "R6" : "R5",
                   p, pad_out[p], pad_oe[p], func_out[e*NP+p], func_oe[e*NP+p]);
        end
      end
      checks++;
      if (func_in !== efi) begin bad++; $display("FAIL R7 func_in act=%h exp=%h", func_in, efi); end
      checks++;
      if (irq_sel0 !== m_irq[0] || irq_sel1 !== m_irq[1]) begin
        bad++; $display("FAIL R4 irq act=%h/%h exp=%h/%h", irq_sel0, irq_sel1, m_irq[0], m_irq[1]);
      end
      checks++;
      if (reg_rdata !== m_rd) begin
        bad++; $display("FAIL %s rdata act=%h exp=%h", m_rd_unm ? "R9" : "R3", reg_rdata, m_rd);
      end
    end
  end

  // Fresh function and pad data each cycle
  initial forever begin
    @(posedge clk); #1;
    for (int i = 0; i < NF*NP/32; i++) begin
      func_out[i*32 +: 32] = $urandom;
      func_oe[i*32 +: 32]  = $urandom;
    end
    pad_in = {$urandom, $urandom};
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    reg_en = 1; reg_wr = 0; reg_addr = a;
    step();
    reg_en = 0;
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp) begin bad++; $display("FAIL %s read %h act=%h exp=%h", tag, a, reg_rdata, exp); end
    step();
  endtask

  task automatic bit_chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%b exp=%b", tag, act, exp); end
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1: reset values
    rd_chk("R1", 8'h20, 32'h0);
    rd_chk("R1", 8'h34, 32'h0);
    rd_chk("R1", 8'h00, 32'h0);
    @(negedge clk);
    bit_chk("R1 pad7 on group0", pad_out[7], func_out[7]);

    // R2/R3: pins 0..7 of port A select 0,1,2,3,E,D,7,F
    wr(8'h20, 32'hF7DE_3210);
    @(negedge clk);
    bit_chk("R5 pin1 group1", pad_out[1], func_out[1*NP+1]);
    bit_chk("R6 pin3 absent group3", pad_out[3], func_out[3]);
    bit_chk("R6 pin4 absent group14", pad_oe[4], func_oe[4]);
    bit_chk("R7 pin1 input to group1", func_in[1*NP+1], pad_in[1]);
    bit_chk("R7 pin1 group0 idle", func_in[1], 1'b0);
    rd_chk("R3 stored absent value", 8'h20, 32'hF7DE_3210);
    wr(8'h2C, 32'h0000_00D0);                       // port B pin 9 -> group 13
    @(negedge clk);
    bit_chk("R2 port B pin9 group13", pad_out[25], func_out[13*NP+25]);

    // R4: interrupt words
    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h04, 32'h1234_5678);
    rd_chk("R4", 8'h00, 32'hDEAD_BEEF);
    rd_chk("R4", 8'h04, 32'h1234_5678);

    // R8: sticky lock on pin 2, then same-cycle lock on port B pin 1
    pin_lock[2] = 1; step(); pin_lock[2] = 0;
    wr(8'h20, 32'h0);
    rd_chk("R8 pin2 held", 8'h20, 32'h0000_0200);
    pin_lock[17] = 1;
    wr(8'h28, 32'h5555_5555);
    pin_lock[17] = 0;
    rd_chk("R8 same-cycle lock", 8'h28, 32'h5555_5505);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R8 lock persists", 8'h28, 32'hFFFF_FF0F);

    // R9: unmapped and misaligned accesses
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h22, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped", 8'h10, 32'h0);
    rd_chk("R9 misaligned", 8'h21, 32'h0);
    rd_chk("R9 beyond", 8'h38, 32'h0);
    rd_chk("R9 no side effect", 8'h20, 32'h0000_0200);

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      int pick = $urandom_range(0, 9);
      logic [7:0] a;
      case (pick)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h14; 3: a = 8'h3C; 4: a = 8'h23;
        default: a = 8'h20 + 8'(4 * $urandom_range(0, 5));
      endcase
      reg_en = ($urandom_range(0, 3) != 0); reg_wr = $urandom_range(0, 1);
      reg_addr = a; reg_wdata = $urandom;
      pin_lock = ($urandom_range(0, 15) == 0) ? (48'h1 << $urandom_range(0, 47)) : '0;
      step();
    end
    reg_en = 0; pin_lock = '0;

    // R1/R8: reset clears locks
    rst_n = 0; repeat (3) step(); rst_n = 1; step();
    rd_chk("R1 after reset", 8'h20, 32'h0);
    wr(8'h20, 32'h1111_1111);
    rd_chk("R8 lock cleared", 8'h20, 32'h1111_1111);
    repeat (4) step();
    finish_run();
  end
endmodule